// File: doc/BRIEF.md
# Three-wire wiper position controller

This block sets the tap of a 32-step digital potentiometer from three slow control wires: an active-low select, an active-low increment strobe and an up/down direction level. The wires are brought into the system clock domain through two-flop synchronizers. While the block is selected, each falling edge of the strobe moves a 5-bit position counter by one step in the chosen direction. The counter is decoded into a one-hot tap select that drives the switch network, and it stops at either end of the range.

Releasing select ends a session. If the strobe is high at that moment, the current position is committed to a modelled nonvolatile cell. The cell then reports busy for a fixed number of clock cycles, and during that time the block ignores strobe edges and new select assertions. If the strobe is low at release, nothing is written and the position is held. The cell keeps its content across the synchronous reset, which stands for a power cycle: on reset the counter is reloaded from the cell, so the wiper comes back at the last committed position. A blank cell holds the parameter value `NV_INIT`.

Top module: `wiper_ctl`

## Requirements
- R1: During and after reset, `position` equals the value in the nonvolatile cell (`NV_INIT`, default 16, before any write), `busy` is 0 and `standby` is 1.
- R2: `tap_sel` always has exactly one bit set, and that bit's index equals `position`.
- R3: While selected (`sel_n` low, session opened by a falling edge of `sel_n`), each falling edge of `inc_n` moves `position` by one step: up when `up_dn` is 1 at that edge, down when it is 0.
- R4: The counter saturates: a step up at 31 leaves 31, and a step down at 0 leaves 0.
- R5: Edges on `inc_n` while `sel_n` is high do not change `position`.
- R6: A rising edge of `sel_n` while `inc_n` is high ends the session and writes `position` into the cell; the next reset reloads that value.
- R7: A rising edge of `sel_n` while `inc_n` is low ends the session without a write: `position` is held, `busy` stays 0, and the next reset reloads the previously stored value.
- R8: After a write, `busy` is 1 for exactly `STORE_CYCLES` clock cycles; `standby` is 0 while a session is open or `busy` is 1, and 1 otherwise.
- R9: While `busy` is 1, falling edges of `sel_n` and `inc_n` are ignored; a select held low across the end of `busy` does not open a session until `sel_n` is released and asserted again.
- R10: `up_dn` may change between steps inside one session, and each step follows the level at its own strobe edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, models a power cycle |
| sel_n | input | 1 | Active-low select, asynchronous |
| inc_n | input | 1 | Active-low step strobe, asynchronous |
| up_dn | input | 1 | Step direction, 1 = up, 0 = down |
| tap_sel | output | 32 | One-hot tap switch enables, bit i closes tap i |
| position | output | 5 | Current counter value |
| busy | output | 1 | Nonvolatile write in progress |
| standby | output | 1 | No session open and no write in progress |

## Verification
The hardest situation to reach is the busy window overlapping a new session attempt. Select is pulled low right after a write has started and held low until busy drops, with strobe pulses both inside and after the window. The position must not move in either case, and a session must open only after a fresh select release and assertion. Committed and discarded writes are told apart only through a later reset, which restores the last committed position at the ports.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    // session state of the controller
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } wpc_state_t;

    // synchronized control levels
    typedef struct packed {
        logic sel;
        logic inc;
        logic dir;
    } wpc_lines_t;

    // edge events derived from the synchronized levels
    typedef struct packed {
        logic sel_fall;
        logic sel_rise;
        logic inc_fall;
    } wpc_events_t;

    localparam int LINE_COUNT = 3;

    // saturating single step in either direction
    function automatic int unsigned sat_step(int unsigned pos, logic up, int unsigned top);
        if (up) begin
            return (pos >= top) ? top : pos + 1;
        end
        return (pos == 0) ? 0 : pos - 1;
    endfunction

endpackage

// File: rtl/wpc_sync.sv
module wpc_sync #(
    parameter int               W      = 3,
    parameter int               STAGES = 2,
    parameter logic [W-1:0]     RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/wpc_nvm.sv
module wpc_nvm #(
    parameter int             POS_W        = 5,
    parameter int             STORE_CYCLES = 500,
    parameter logic [POS_W-1:0] NV_INIT    = 5'd16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [POS_W-1:0] wr_data,
    output logic [POS_W-1:0] nv_value,
    output logic             busy
);
    localparam int CNT_W = $clog2(STORE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STORE_CYCLES - 1);

    // retained cell: not touched by reset, which models a power cycle
    logic [POS_W-1:0] nv_q = NV_INIT;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (wr_en) nv_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (wr_en) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_LOAD;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign nv_value = nv_q;
    assign busy     = busy_q;

    // R6: a write lands in the cell and starts the busy window
    p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (busy_q && nv_q == $past(wr_data)));

    // R7: without a write the cell keeps its content
    p_cell_kept_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(nv_q));

    // R9: no write is requested while one is running
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !busy_q);

    // R8: the timer stays inside its window
    p_timer_bound_r8: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q <= CNT_LOAD));
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
    import wpc_pkg::*;
#(
    parameter int TAPS  = 32,
    parameter int POS_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  wpc_lines_t       lines,
    input  logic             busy,
    input  logic [POS_W-1:0] nv_value,
    output logic [POS_W-1:0] pos,
    output logic             wr_en,
    output logic [POS_W-1:0] wr_data,
    output logic             standby
);
    localparam logic [POS_W-1:0] POS_MAX = POS_W'(TAPS - 1);

    wpc_state_t       state_q, state_d;
    logic             sel_prev, inc_prev;
    wpc_events_t      ev;
    logic [POS_W-1:0] pos_q;
    logic             step_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_prev <= 1'b1;
            inc_prev <= 1'b1;
        end else begin
            sel_prev <= lines.sel;
            inc_prev <= lines.inc;
        end
    end

    always_comb begin
        ev.sel_fall = sel_prev & ~lines.sel;
        ev.sel_rise = ~sel_prev & lines.sel;
        ev.inc_fall = inc_prev & ~lines.inc;
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (ev.sel_fall && !busy) state_d = ST_ACTIVE;
            ST_ACTIVE: if (ev.sel_rise)          state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    assign step_en = (state_q == ST_ACTIVE) && ev.inc_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pos_q   <= nv_value;
        end else begin
            state_q <= state_d;
            if (step_en)
                pos_q <= POS_W'(sat_step(32'(pos_q), lines.dir, 32'(POS_MAX)));
        end
    end

    assign wr_en   = (state_q == ST_ACTIVE) && ev.sel_rise && lines.inc;
    assign wr_data = pos_q;
    assign pos     = pos_q;
    assign standby = (state_q == ST_IDLE) && !busy;

    // R5: the counter moves only on an accepted strobe edge
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(pos_q));

    // R3: a step up below the top adds one
    p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
        (step_en && lines.dir && pos_q != POS_MAX) |=> (pos_q == $past(pos_q) + 1'b1));

    // R3: a step down above zero subtracts one
    p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
        (step_en && !lines.dir && pos_q != '0) |=> (pos_q == $past(pos_q) - 1'b1));

    // R4: no wrap at the top
    p_sat_top_r4: assert property (@(posedge clk) disable iff (rst)
        (step_en && lines.dir && pos_q == POS_MAX) |=> (pos_q == POS_MAX));

    // R4: no wrap at the bottom
    p_sat_bottom_r4: assert property (@(posedge clk) disable iff (rst)
        (step_en && !lines.dir && pos_q == '0) |=> (pos_q == '0));

    // R9: no session is open while the cell is busy
    p_busy_idle_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (state_q == ST_IDLE));
endmodule

// File: rtl/wpc_decode.sv
module wpc_decode #(
    parameter int TAPS  = 32,
    parameter int POS_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] pos,
    output logic [TAPS-1:0]  tap
);
    generate
        for (genvar i = 0; i < TAPS; i++) begin : g_tap
            assign tap[i] = (pos == POS_W'(i));
        end
    endgenerate

    // R2: exactly one switch closed at any time
    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(tap) == 1);
endmodule

// File: rtl/wiper_ctl.sv
module wiper_ctl #(
    parameter int TAPS         = 32,
    parameter int STORE_CYCLES = 500,
    parameter int NV_INIT      = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int POS_W        = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_n,
    input  logic             inc_n,
    input  logic             up_dn,
    output logic [TAPS-1:0]  tap_sel,
    output logic [POS_W-1:0] position,
    output logic             busy,
    output logic             standby
);
    import wpc_pkg::*;

    wpc_lines_t       raw, synced;
    logic             wr_en;
    logic [POS_W-1:0] wr_data, nv_value, pos;

    assign raw = '{sel: sel_n, inc: inc_n, dir: up_dn};

    wpc_sync #(
        .W       (LINE_COUNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (raw),
        .q_sync  (synced)
    );

    wpc_ctrl #(
        .TAPS  (TAPS),
        .POS_W (POS_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .lines    (synced),
        .busy     (busy),
        .nv_value (nv_value),
        .pos      (pos),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .standby  (standby)
    );

    wpc_nvm #(
        .POS_W        (POS_W),
        .STORE_CYCLES (STORE_CYCLES),
        .NV_INIT      (POS_W'(NV_INIT))
    ) u_nvm (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .nv_value (nv_value),
        .busy     (busy)
    );

    wpc_decode #(
        .TAPS  (TAPS),
        .POS_W (POS_W)
    ) u_decode (
        .clk (clk),
        .rst (rst),
        .pos (pos),
        .tap (tap_sel)
    );

    assign position = pos;
endmodule

// File: tb/wiper_ctl_test.sv
module wiper_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int STORE_CYC  = 40;
    localparam int TAPS       = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1;
    logic        inc_n = 1'b1;
    logic        up_dn = 1'b0;
    logic [31:0] tap_sel;
    logic [4:0]  position;
    logic        busy, standby;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        int    pos;
        bit    busy;
        bit    stby;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_ctl #(.TAPS(TAPS), .STORE_CYCLES(STORE_CYC), .NV_INIT(16)) uut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .inc_n(inc_n), .up_dn(up_dn),
        .tap_sel(tap_sel), .position(position), .busy(busy), .standby(standby)
    );

    task automatic check_int(int act, int exp, string tag);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected items and compares them with the ports
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                logic [31:0] want;
                e = sb_q.pop_front();
                want = 32'd1 << e.pos;
                check_int(int'(position), e.pos, {e.tag, " position"});
                n_checks++;
                if (tap_sel !== want) begin
                    n_errors++;
                    $display("FAIL R2 %s tap: actual %h expected %h", e.tag, tap_sel, want);
                end
                check_int(int'(busy), int'(e.busy), {e.tag, " busy"});
                check_int(int'(standby), int'(e.stby), {e.tag, " standby"});
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_state(int pos, bit b, bit s, string tag);
        sb_q.push_back('{pos: pos, busy: b, stby: s, tag: tag});
        wait (sb_q.size() == 0);
        settle(1);
    endtask

    task automatic power_cycle();
        rst = 1'b1;
        settle(3);
        rst = 1'b0;
        settle(3);
    endtask

    task automatic select();
        sel_n = 1'b0;
        settle(5);
    endtask

    task automatic step(bit dir);
        up_dn = dir;
        settle(4);
        inc_n = 1'b0;
        settle(5);
        inc_n = 1'b1;
        settle(5);
    endtask

    task automatic release_store();
        inc_n = 1'b1;
        sel_n = 1'b1;
        settle(5);
    endtask

    task automatic step_release_nostore(bit dir);
        up_dn = dir;
        settle(4);
        inc_n = 1'b0;
        settle(5);
        sel_n = 1'b1;
        settle(5);
        inc_n = 1'b1;
        settle(5);
    endtask

    task automatic wait_not_busy();
        for (int i = 0; i < 500; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        settle(2);
    endtask

    initial begin
        int blen;
        settle(3);
        // R1: reset state with blank cell
        expect_state(16, 0, 1, "R1 during reset");
        rst = 1'b0;
        settle(3);
        expect_state(16, 0, 1, "R1 after reset");

        select();
        expect_state(16, 0, 0, "R8 session open");
        step(1); step(1); step(1);
        expect_state(19, 0, 0, "R3 three up");
        step(0);
        expect_state(18, 0, 0, "R10 direction change");

        // R8: busy length after a committed write
        inc_n = 1'b1;
        sel_n = 1'b1;
        blen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (busy) blen++;
            else if (blen > 0) break;
        end
        check_int(blen, STORE_CYC, "R8 busy length");
        settle(2);
        expect_state(18, 0, 1, "R8 standby after write");

        power_cycle();
        expect_state(18, 0, 1, "R6 reload stored");

        // R9: session attempt during busy
        select();
        step(1); step(1);
        expect_state(20, 0, 0, "R3 two up");
        release_store();
        expect_state(20, 1, 0, "R8 busy after release");
        sel_n = 1'b0;
        settle(2);
        step(1);
        expect_state(20, 1, 0, "R9 strobe ignored while busy");
        wait_not_busy();
        step(1);
        expect_state(20, 0, 1, "R9 held select does not open");
        sel_n = 1'b1;
        settle(5);
        select();
        step(1);
        expect_state(21, 0, 0, "R9 reselect opens session");

        // R7: release with strobe low
        step_release_nostore(1);
        expect_state(22, 0, 1, "R7 no write on release");
        step(1); step(0); step(0);
        expect_state(22, 0, 1, "R5 strobes while deselected");
        power_cycle();
        expect_state(20, 0, 1, "R7 reload older value");

        // R4: saturation at both ends
        select();
        for (int i = 0; i < 11; i++) step(1);
        expect_state(31, 0, 0, "R3 climb to top");
        step(1);
        expect_state(31, 0, 0, "R4 top saturates");
        for (int i = 0; i < 31; i++) step(0);
        expect_state(0, 0, 0, "R3 descend to bottom");
        step(0);
        expect_state(0, 0, 0, "R4 bottom saturates");
        release_store();
        wait_not_busy();
        power_cycle();
        expect_state(0, 0, 1, "R6 reload zero");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule